// File: doc/BRIEF.md
# Asynchronous Memory Strobe Timer

This block runs one access to an external asynchronous parallel memory. A single-clock start pulse and a read/write flag begin the access. The block then counts ticks from the start and drives four active-low strobes: chip select, address valid, output enable and write enable. Each strobe goes low and high again at tick values taken from packed timing words. A tick lasts one or more functional clocks, as set by a 2-bit divider field.

On a read, the block gives a one-clock capture pulse at the programmed access tick, so that a neighbouring datapath can latch the bus. A one-clock done pulse ends every access. The following clock can accept a new start. The timing words are expected to stay stable during an access. The read/write flag and the divider value are latched when the start is accepted.

Top module: `amt_top`

## Requirements
- R1: While rst_ni is low, and afterwards until a start is accepted, all four strobes are high and cap_o and done_o are low.
- R2: A start is accepted only when the block is idle, and the clock after acceptance is tick 0. A start raised during an access, including its done clock, has no effect, and the block is idle on the clock that follows done.
- R3: A tick advances every (D+1) functional clocks, where D is div_i bits 1:0, latched at start. An access of cycle length L therefore lasts (L+1)*(D+1) clocks.
- R4: cs_no is low on ticks T with on <= T < off. The on tick is cs_tim_i bits 3:0. The off tick is cs_tim_i bits 12:8 on reads and bits 20:16 on writes.
- R5: adv_no follows the same rule as R4, using adv_tim_i with the same field positions.
- R6: oe_no is low only on reads, from strb_tim_i bits 3:0 up to bits 12:8. we_no is low only on writes, from strb_tim_i bits 19:16 up to bits 28:24.
- R7: A strobe whose off tick is less than or equal to its on tick never goes low. No strobe is low on ticks at or beyond the cycle length.
- R8: On reads, cap_o pulses for one clock on the last functional clock of tick A, where A is cyc_tim_i bits 20:16. cap_o never pulses on writes.
- R9: done_o pulses for one clock on the last functional clock of tick L. L is cyc_tim_i bits 4:0 on reads and bits 12:8 on writes. A length of 0 ends the access after one tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | functional clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| start_i | input | 1 | begin an access |
| wr_i | input | 1 | 1 = write, 0 = read; sampled with start_i |
| div_i | input | 32 | mode word; bits 1:0 are the divider field |
| cs_tim_i | input | 32 | chip-select on/read-off/write-off ticks |
| adv_tim_i | input | 32 | address-valid on/read-off/write-off ticks |
| strb_tim_i | input | 32 | output-enable and write-enable on/off ticks |
| cyc_tim_i | input | 32 | read length, write length, access tick |
| cs_no | output | 1 | chip select, active low |
| adv_no | output | 1 | address valid, active low |
| oe_no | output | 1 | output enable, active low |
| we_no | output | 1 | write enable, active low |
| cap_o | output | 1 | data-capture pulse on reads |
| done_o | output | 1 | end-of-access pulse |

## Verification
The bench builds the block with the default 32-bit timing words and 5-bit tick fields. With these defaults, off ticks of 31 fall beyond any short cycle, which exercises the clipping at the cycle length. All four divider settings are used, so the tick-stretching path and the last-clock placement of done and capture are checked at every ratio. Zero-length cycles, inverted windows, an access tick equal to the length, and starts raised mid-access and on the done clock all fit in the 5-bit range.

// File: rtl/amt_pkg.sv
package amt_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned TICK_W = 5;
  localparam int unsigned DIV_W  = 2;
  localparam int unsigned N_STRB = 4;

  // field positions shared with software that packs the timing words
  localparam int unsigned ON_LSB   = 0;
  localparam int unsigned ON_W     = 4;
  localparam int unsigned ROFF_LSB = 8;
  localparam int unsigned WOFF_LSB = 16;
  localparam int unsigned OFF_W    = 5;
  localparam int unsigned WEON_LSB = 16;
  localparam int unsigned WEOFF_LSB= 24;
  localparam int unsigned RLEN_LSB = 0;
  localparam int unsigned WLEN_LSB = 8;
  localparam int unsigned ACC_LSB  = 16;

  typedef logic [TICK_W-1:0] tick_t;
  typedef logic [DIV_W-1:0]  div_t;

  typedef enum int unsigned { S_CS = 0, S_ADV = 1, S_OE = 2, S_WE = 3 } strb_e;

  function automatic tick_t fld(logic [REG_W-1:0] r, int unsigned lsb, int unsigned w);
    logic [REG_W-1:0] s;
    s = (r >> lsb) & ((REG_W'(1) << w) - REG_W'(1));
    return s[TICK_W-1:0];
  endfunction
endpackage

// File: rtl/amt_div.sv
module amt_div
  import amt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  input  div_t div_i,
  output logic last_o
);
  div_t ph_q;

  assign last_o = (ph_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ph_q <= '0;
    else if (clr_i) ph_q <= '0;
    else if (run_i) ph_q <= last_o ? '0 : ph_q + div_t'(1);
  end
endmodule

// File: rtl/amt_cnt.sv
module amt_cnt
  import amt_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  start_i,
  input  logic  last_i,
  input  tick_t len_i,
  output logic  accept_o,
  output logic  busy_o,
  output tick_t tick_o,
  output logic  done_o
);
  logic  busy_q;
  tick_t tick_q;

  assign accept_o = start_i & ~busy_q;
  assign done_o   = busy_q & last_i & (tick_q == len_i);
  assign busy_o   = busy_q;
  assign tick_o   = tick_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      tick_q <= '0;
    end else if (accept_o) begin
      busy_q <= 1'b1;
      tick_q <= '0;
    end else if (done_o) begin
      busy_q <= 1'b0;
    end else if (busy_q && last_i) begin
      tick_q <= tick_q + tick_t'(1);
    end
  end
endmodule

// File: rtl/amt_win.sv
module amt_win
  import amt_pkg::*;
(
  input  logic  en_i,
  input  tick_t tick_i,
  input  tick_t on_i,
  input  tick_t off_i,
  output logic  act_o
);
  // empty window when off <= on falls out of the compare naturally
  assign act_o = en_i & (tick_i >= on_i) & (tick_i < off_i);
endmodule

// File: rtl/amt_top.sv
module amt_top
  import amt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             wr_i,
  input  logic [REG_W-1:0] div_i,
  input  logic [REG_W-1:0] cs_tim_i,
  input  logic [REG_W-1:0] adv_tim_i,
  input  logic [REG_W-1:0] strb_tim_i,
  input  logic [REG_W-1:0] cyc_tim_i,
  output logic             cs_no,
  output logic             adv_no,
  output logic             oe_no,
  output logic             we_no,
  output logic             cap_o,
  output logic             done_o
);
  logic  accept, busy, last, wr_q, live;
  div_t  div_q;
  tick_t tick, len, acc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= 1'b0;
      div_q <= '0;
    end else if (accept) begin
      wr_q  <= wr_i;
      div_q <= div_i[DIV_W-1:0];
    end
  end

  assign len = wr_q ? fld(cyc_tim_i, WLEN_LSB, OFF_W) : fld(cyc_tim_i, RLEN_LSB, OFF_W);
  assign acc = fld(cyc_tim_i, ACC_LSB, OFF_W);

  amt_div u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (accept),
    .run_i  (busy),
    .div_i  (div_q),
    .last_o (last)
  );

  amt_cnt u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .last_i   (last),
    .len_i    (len),
    .accept_o (accept),
    .busy_o   (busy),
    .tick_o   (tick),
    .done_o   (done_o)
  );

  assign live  = busy & (tick < len);
  assign cap_o = busy & ~wr_q & last & (tick == acc);

  tick_t               on_a  [N_STRB];
  tick_t               off_a [N_STRB];
  logic [N_STRB-1:0]   en_a, act_a;

  always_comb begin
    on_a[S_CS]   = fld(cs_tim_i, ON_LSB, ON_W);
    off_a[S_CS]  = fld(cs_tim_i, wr_q ? WOFF_LSB : ROFF_LSB, OFF_W);
    on_a[S_ADV]  = fld(adv_tim_i, ON_LSB, ON_W);
    off_a[S_ADV] = fld(adv_tim_i, wr_q ? WOFF_LSB : ROFF_LSB, OFF_W);
    on_a[S_OE]   = fld(strb_tim_i, ON_LSB, ON_W);
    off_a[S_OE]  = fld(strb_tim_i, ROFF_LSB, OFF_W);
    on_a[S_WE]   = fld(strb_tim_i, WEON_LSB, ON_W);
    off_a[S_WE]  = fld(strb_tim_i, WEOFF_LSB, OFF_W);
    en_a[S_CS]   = live;
    en_a[S_ADV]  = live;
    en_a[S_OE]   = live & ~wr_q;
    en_a[S_WE]   = live & wr_q;
  end

  for (genvar g = 0; g < N_STRB; g++) begin : g_win
    amt_win u_win (
      .en_i   (en_a[g]),
      .tick_i (tick),
      .on_i   (on_a[g]),
      .off_i  (off_a[g]),
      .act_o  (act_a[g])
    );
  end

  assign cs_no  = ~act_a[S_CS];
  assign adv_no = ~act_a[S_ADV];
  assign oe_no  = ~act_a[S_OE];
  assign we_no  = ~act_a[S_WE];
endmodule

// File: rtl/amt_chk.sv
module amt_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic busy_i,
  input logic wr_i,
  input logic cs_ni,
  input logic adv_ni,
  input logic oe_ni,
  input logic we_ni,
  input logic cap_i,
  input logic done_i
);
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> (cs_ni && adv_ni && oe_ni && we_ni && !cap_i && !done_i)); // R1

  AST_START_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && start_i) |=> busy_i); // R2

  AST_DONE_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> (!busy_i && !done_i)); // R9

  AST_OE_WE_APART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!oe_ni && !we_ni)); // R6

  AST_OE_READ_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_ni |-> !wr_i); // R6

  AST_CAP_READ_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |-> !wr_i); // R8

  AST_CAP_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |=> !cap_i); // R8
endmodule

bind amt_top amt_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .busy_i  (busy),
  .wr_i    (wr_q),
  .cs_ni   (cs_no),
  .adv_ni  (adv_no),
  .oe_ni   (oe_no),
  .we_ni   (we_no),
  .cap_i   (cap_o),
  .done_i  (done_o)
);

// File: tb/sim_amt_top.sv
`timescale 1ns/1ps
module sim_amt_top;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, wr = 1'b0;
  logic [31:0] div_w = '0, cs_t = '0, adv_t = '0, st_t = '0, cyc_t = '0;
  logic cs_n, adv_n, oe_n, we_n, cap, done;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  amt_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .wr_i(wr), .div_i(div_w),
    .cs_tim_i(cs_t), .adv_tim_i(adv_t), .strb_tim_i(st_t), .cyc_tim_i(cyc_t),
    .cs_no(cs_n), .adv_no(adv_n), .oe_no(oe_n), .we_no(we_n),
    .cap_o(cap), .done_o(done)
  );

  // wr, div, cs_on, cs_roff, cs_woff, av_on, av_roff, av_woff,
  // oe_on, oe_off, we_on, we_off, rlen, wlen, acc
  localparam int NV = 7;
  localparam int TV [NV][15] = '{
    '{0,0, 1,6,7,   0,2,2,   2,6,  1,5,  8,9,5},
    '{1,0, 1,6,7,   0,2,3,   2,6,  1,5,  8,9,5},
    '{0,2, 0,4,4,   0,1,1,   1,4,  1,3,  5,5,3},
    '{1,3, 2,9,9,   0,1,1,   0,0,  3,8,  4,10,2},
    '{0,0, 3,3,3,   5,2,2,   4,9,  0,0,  6,6,6},
    '{0,1, 0,31,31, 0,31,31, 0,31, 0,31, 3,3,0},
    '{1,0, 0,5,5,   0,5,5,   0,5,  0,0,  0,0,0}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] pk3(int a, int b, int c);
    return 32'((c << 16) | (b << 8) | a);
  endfunction

  task automatic idle_chk(input string tag);
    @(negedge clk);
    start = 1'b0;
    chk({cs_n, adv_n, oe_n, we_n} == 4'hF, tag, int'({cs_n, adv_n, oe_n, we_n}), 15);
    chk(!done && !cap, tag, int'({done, cap}), 0);
  endtask

  task automatic run_vec(input int i, input bit poke, input bit done_poke);
    int wv, d, len, t;
    bit last, live, e;
    string s7;
    wv  = TV[i][0];
    d   = TV[i][1];
    len = wv ? TV[i][13] : TV[i][12];
    s7  = (i == 4 || i == 5) ? "R7" : "";
    @(negedge clk);
    div_w = 32'(d);
    cs_t  = pk3(TV[i][2], TV[i][3], TV[i][4]);
    adv_t = pk3(TV[i][5], TV[i][6], TV[i][7]);
    st_t  = 32'((TV[i][11] << 24) | (TV[i][10] << 16) | (TV[i][9] << 8) | TV[i][8]);
    cyc_t = pk3(TV[i][12], TV[i][13], TV[i][14]);
    wr    = wv[0];
    start = 1'b1;
    @(posedge clk);
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      if (k == 0) start = 1'b0;
      t    = k / (d + 1);
      last = (k % (d + 1)) == d;
      live = t < len;
      e = live && t >= TV[i][2] && t < (wv ? TV[i][4] : TV[i][3]);
      chk(cs_n == !e, {"R4 cs ", s7}, int'(cs_n), int'(!e));
      e = live && t >= TV[i][5] && t < (wv ? TV[i][7] : TV[i][6]);
      chk(adv_n == !e, {"R5 adv ", s7}, int'(adv_n), int'(!e));
      e = live && !wv && t >= TV[i][8] && t < TV[i][9];
      chk(oe_n == !e, {"R6 oe ", s7}, int'(oe_n), int'(!e));
      e = live && wv && t >= TV[i][10] && t < TV[i][11];
      chk(we_n == !e, {"R6 we ", s7}, int'(we_n), int'(!e));
      e = !wv && last && t == TV[i][14];
      chk(cap == e, "R8 cap", int'(cap), int'(e));
      e = last && t == len;
      chk(done == e, "R9 done", int'(done), int'(e));
      if (poke && k == 1) start = 1'b1;
      if (poke && k == 2) start = 1'b0;
      if (e) begin
        chk(k + 1 == (len + 1) * (d + 1), "R3 length", k + 1, (len + 1) * (d + 1));
        if (done_poke) start = 1'b1;
        break;
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    // R1: reset holds idle even with start raised
    start = 1'b1;
    repeat (3) @(negedge clk);
    chk({cs_n, adv_n, oe_n, we_n} == 4'hF, "R1 reset strobes", int'({cs_n, adv_n, oe_n, we_n}), 15);
    chk(!done && !cap, "R1 reset pulses", int'({done, cap}), 0);
    start = 1'b0;
    rst_n = 1'b1;
    idle_chk("R1 after reset");
    idle_chk("R1 idle");

    for (int i = 0; i < NV; i++) begin
      run_vec(i, 1'b0, 1'b0);
      idle_chk("R2 idle after done");
    end

    // R2: start mid-access is ignored; length and strobes unchanged
    run_vec(3, 1'b1, 1'b0);
    idle_chk("R2 mid-access start");
    run_vec(0, 1'b1, 1'b0);
    idle_chk("R2 mid-access start");

    // R2: start on the done clock is ignored (cs would be low at tick 0)
    run_vec(2, 1'b0, 1'b1);
    idle_chk("R2 done-clock start");
    idle_chk("R2 still idle");

    // back-to-back accepted on the clock after done
    run_vec(1, 1'b0, 1'b0);
    run_vec(4, 1'b0, 1'b0);
    idle_chk("R2 idle");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule